// File: doc/BRIEF.md
# Timer Clock-Source Prescaler with Halt-and-Release Control

This block sits in the I/O clock domain and decides when a downstream timer/counter may advance. It produces a single-cycle count-enable strobe. The strobe comes from one of three kinds of source. The first is the undivided I/O clock. The second is one of four taps of a free-running 10-bit prescaler, dividing by 8, 64, 256 or 1024. The third is an external pin, which passes through a two-flop synchronizer and an edge detector. The pin is never divided. It should toggle below one half of the I/O clock rate, and a comfortable margin is below one 2.5th of it.

A single control register holds two writable bits: a halt-mode flag and a prescaler-clear flag. With halt mode off, a clear request lasts only one cycle, because hardware drops it on the next clock. With halt mode on, the clear request sticks. The prescaler then stays at zero and no enable strobe is produced, so software can reconfigure the timer safely. Writing halt mode back to zero releases the prescaler, and counting restarts from a known phase.

Top module: `tcs_clksrc`

## Requirements
- R1: After reset, `rd_data` reads 0x00 and `cnt_en` is low.
- R2: Register layout:
  - Bit 7 is the halt-mode flag.
  - Bit 0 is the prescaler-clear flag.
  - Bits 6..1 always read 0, whatever value is written to them.
  - A write stores bits 7 and 0 at the next clock edge.
- R3: With halt mode 0, a clear flag written as 1 reads back as 1 for exactly one cycle. Hardware then returns it to 0.
- R4: With halt mode 1, a clear flag written as 1 stays at 1. While it is 1, the prescaler is held at zero and `cnt_en` stays low for every `clk_sel` value, including the external-pin modes.
- R5: Writing 0x00 while halted clears both flags at that write's edge E. With divide-by-N selected, the first `cnt_en` pulse is asserted after edge E+N.
- R6: `clk_sel` 000 never produces a pulse. `clk_sel` 001 holds `cnt_en` high on every cycle in which the clear flag was 0 on the previous cycle.
- R7: `clk_sel` values 010, 011, 100 and 101 divide by 8, 64, 256 and 1024. After the clear flag drops at edge E, pulses are asserted after edges E+N, E+2N, and so on.
- R8: `clk_sel` 111 pulses on a rising pin edge and 110 pulses on a falling pin edge; the other edge direction gives no pulse. A pin level first sampled at edge P produces a pulse asserted after edge P+2.
- R9: If the clear flag is 1 in the cycle where the prescaler sits at a tap's all-ones value, that tick is dropped. The next pulse then follows the post-clear phase.
- R10: For every `clk_sel` other than 001, `cnt_en` is never high for two cycles in a row while `clk_sel` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value |
| clk_sel | input | 3 | Clock source select |
| ext_pin | input | 1 | External clock pin, asynchronous |
| cnt_en | output | 1 | One-cycle count-enable strobe for the timer |

## Verification
Two functions can fall in the same cycle: a prescaler clear arriving from a register write, and the prescaler reaching the all-ones value of the selected tap. The bench provokes this by releasing the prescaler, then timing a second clear write so that its edge lands exactly as the counter reaches 7 with divide-by-8 selected. The test passes only if the pulse that would have appeared two cycles later is missing and the next pulse arrives N cycles after the second release. Hold mode is also combined with external pin toggles, and the bench confirms that no edge leaks through.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    typedef enum logic [2:0] {
        SEL_STOP     = 3'd0,
        SEL_DIV1     = 3'd1,
        SEL_DIV8     = 3'd2,
        SEL_DIV64    = 3'd3,
        SEL_DIV256   = 3'd4,
        SEL_DIV1024  = 3'd5,
        SEL_EXT_FALL = 3'd6,
        SEL_EXT_RISE = 3'd7
    } clk_sel_e;

    typedef struct packed {
        logic halt;
        logic clr;
    } ctrl_s;

    typedef struct packed {
        logic en;
    } out_s;

endpackage

// File: rtl/tcs_ctrl_reg.sv
module tcs_ctrl_reg
    import tcs_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int HALT_BIT = 7,
    parameter int CLR_BIT  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              clr_o
);

    ctrl_s reg_d, reg_q;
    logic  unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    always_comb begin
        reg_d = reg_q;
        if (wr_en) begin
            reg_d.halt = wr_data[HALT_BIT];
            reg_d.clr  = wr_data[CLR_BIT];
        end else if (!reg_q.halt) begin
            reg_d.clr  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    always_comb begin
        rd_data           = '0;
        rd_data[HALT_BIT] = reg_q.halt;
        rd_data[CLR_BIT]  = reg_q.clr;
    end

    assign clr_o = reg_q.clr;

    AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !reg_q.halt) |=> !reg_q.clr); // R3
    AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && reg_q.halt && reg_q.clr) |=> reg_q.clr); // R4
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[CLR_BIT] == $past(wr_data[CLR_BIT]))); // R2

endmodule

// File: rtl/tcs_prescaler.sv
module tcs_prescaler #(
    parameter int                CNT_W    = 10,
    parameter int                NTAP     = 4,
    parameter logic [NTAP*8-1:0] TAP_LOG2 = {8'd10, 8'd8, 8'd6, 8'd3}
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    output logic [NTAP-1:0] tick
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } presc_s;

    presc_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.cnt = '0;
        else     st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar gi = 0; gi < NTAP; gi++) begin : g_tap
        localparam int L = int'(TAP_LOG2[gi*8 +: 8]);
        assign tick[gi] = &st_q.cnt[L-1:0];
    end

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0)); // R4

endmodule

// File: rtl/tcs_ext_edge.sv
module tcs_ext_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } edge_s;

    edge_s st_d, st_q;
    logic  synced;

    assign synced = st_q.chain[STAGES-1];

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], pin};
        st_d.prev  = synced;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = synced & ~st_q.prev;
    assign fall = ~synced & st_q.prev;

    AST_RISE_NOT_REPEATED: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R10

endmodule

// File: rtl/tcs_clksrc.sv
module tcs_clksrc
    import tcs_pkg::*;
#(
    parameter int CNT_W       = 10,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [2:0]        clk_sel,
    input  logic              ext_pin,
    output logic              cnt_en
);

    localparam int                NTAP = 4;
    localparam logic [NTAP*8-1:0] TAPS = {8'd10, 8'd8, 8'd6, 8'd3};

    logic            presc_clr;
    logic [NTAP-1:0] tick;
    logic            ext_rise, ext_fall;
    logic            src;
    out_s            out_d, out_q;

    tcs_ctrl_reg #(
        .DATA_W  (DATA_W),
        .HALT_BIT(DATA_W - 1),
        .CLR_BIT (0)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .rd_data(rd_data),
        .clr_o  (presc_clr)
    );

    tcs_prescaler #(
        .CNT_W   (CNT_W),
        .NTAP    (NTAP),
        .TAP_LOG2(TAPS)
    ) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (presc_clr),
        .tick (tick)
    );

    tcs_ext_edge #(
        .STAGES(SYNC_STAGES)
    ) u_ext (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_pin),
        .rise (ext_rise),
        .fall (ext_fall)
    );

    always_comb begin
        src = 1'b0;
        case (clk_sel_e'(clk_sel))
            SEL_STOP:     src = 1'b0;
            SEL_DIV1:     src = 1'b1;
            SEL_DIV8:     src = tick[0];
            SEL_DIV64:    src = tick[1];
            SEL_DIV256:   src = tick[2];
            SEL_DIV1024:  src = tick[3];
            SEL_EXT_FALL: src = ext_fall;
            SEL_EXT_RISE: src = ext_rise;
        endcase
        out_d    = out_q;
        out_d.en = src & ~presc_clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign cnt_en = out_q.en;

    AST_FROZEN_WHILE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        presc_clr |=> !cnt_en); // R4
    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'd0) |=> !cnt_en); // R6
    AST_DIV1_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'd1 && !presc_clr) |=> cnt_en); // R6
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && clk_sel != 3'd1) |=> (!cnt_en || !$stable(clk_sel))); // R10

endmodule

// File: tb/tcs_clksrc_test.sv
`timescale 1ns/1ps
module tcs_clksrc_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic [2:0] clk_sel;
    logic       ext_pin;
    logic       cnt_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [2:0] VSEL [6] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5};
    localparam int         VDIV [6] = '{0, 1, 8, 64, 256, 1024};

    always #2.5 clk = ~clk;

    tcs_clksrc uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .rd_data(rd_data),
        .clk_sel(clk_sel),
        .ext_pin(ext_pin),
        .cnt_en (cnt_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive a write at the current falling edge; returns one falling edge later.
    task automatic wr(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = 8'h00;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int first, cnt, exp_cnt, exp_first;
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_data = 8'h00;
        clk_sel = 3'd0;
        ext_pin = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 rd_data in reset", rd_data, 0);
        chk("R1 cnt_en in reset", cnt_en, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 rd_data after reset", rd_data, 0);
        chk("R1 cnt_en after reset", cnt_en, 0);

        // Table walk: one-cycle clear, then count pulses in falling edges 3..2048.
        for (int i = 0; i < 6; i++) begin
            clk_sel = VSEL[i];
            wr(8'h01);
            first = -1;
            cnt   = 0;
            for (int n = 2; n <= 2048; n++) begin
                @(negedge clk);
                if (n >= 3 && cnt_en) begin
                    cnt++;
                    if (first < 0) first = n;
                end
            end
            exp_cnt   = (VDIV[i] == 0) ? 0 : 2046 / VDIV[i];
            exp_first = (VDIV[i] == 0) ? -1 : VDIV[i] + 2;
            chk($sformatf("R6/R7 pulse count sel=%0d", VSEL[i]), cnt, exp_cnt);
            chk($sformatf("R7 first pulse sel=%0d", VSEL[i]), first, exp_first);
        end

        // R3: self-clearing clear flag.
        clk_sel = 3'd2;
        wr(8'h01);
        chk("R3 clear flag visible one cycle", rd_data, 8'h01);
        @(negedge clk);
        chk("R3 clear flag dropped by hardware", rd_data, 8'h00);

        // R2: read-only bits.
        wr(8'hFF);
        chk("R2 bits 6..1 read zero", rd_data, 8'h81);
        wr(8'h7E);
        chk("R2 middle bits ignored", rd_data, 8'h00);

        // R4: halt mode keeps the clear flag and blocks every source.
        repeat (4) @(negedge clk);
        wr(8'h81);
        cnt = 0;
        for (int n = 2; n <= 50; n++) begin
            @(negedge clk);
            if (n >= 3 && cnt_en) cnt++;
        end
        clk_sel = 3'd7;
        for (int n = 0; n < 60; n++) begin
            if (n % 5 == 0) ext_pin = ~ext_pin;
            @(negedge clk);
            if (cnt_en) cnt++;
        end
        chk("R4 no pulses while halted", cnt, 0);
        chk("R4 clear flag sticks", rd_data, 8'h81);
        ext_pin = 1'b0;
        clk_sel = 3'd2;
        repeat (4) @(negedge clk);

        // R5: release, first pulse one full period later.
        wr(8'h00);
        chk("R5 both flags cleared", rd_data, 8'h00);
        first = -1;
        cnt   = 0;
        for (int n = 2; n <= 40; n++) begin
            @(negedge clk);
            if (cnt_en) begin
                cnt++;
                if (first < 0) first = n;
            end
        end
        chk("R5 first pulse after release", first, 9);
        chk("R5 pulses after release", cnt, 4);

        // R9: clear lands exactly as prescaler reaches all-ones.
        wr(8'h01);
        cnt = 0;
        for (int n = 2; n <= 8; n++) begin
            @(negedge clk);
            if (n >= 3 && cnt_en) cnt++;
        end
        wr(8'h01);
        first = -1;
        for (int n = 2; n <= 12; n++) begin
            @(negedge clk);
            if (cnt_en) begin
                cnt++;
                if (first < 0) first = n;
            end
        end
        chk("R9 colliding tick dropped", first, 10);
        chk("R9 single pulse in window", cnt, 1);

        // R8 / R10: external edges.
        clk_sel = 3'd7;
        repeat (6) @(negedge clk);
        ext_pin = 1'b1;
        first = -1;
        cnt   = 0;
        for (int m = 1; m <= 8; m++) begin
            @(negedge clk);
            if (cnt_en) begin
                cnt++;
                if (first < 0) first = m;
            end
        end
        chk("R8 rising edge latency", first, 3);
        chk("R10 rising edge single pulse", cnt, 1);
        ext_pin = 1'b0;
        cnt = 0;
        for (int m = 1; m <= 8; m++) begin
            @(negedge clk);
            if (cnt_en) cnt++;
        end
        chk("R8 falling edge ignored in rise mode", cnt, 0);
        clk_sel = 3'd6;
        ext_pin = 1'b1;
        cnt = 0;
        for (int m = 1; m <= 8; m++) begin
            @(negedge clk);
            if (cnt_en) cnt++;
        end
        chk("R8 rising edge ignored in fall mode", cnt, 0);
        ext_pin = 1'b0;
        first = -1;
        cnt   = 0;
        for (int m = 1; m <= 8; m++) begin
            @(negedge clk);
            if (cnt_en) begin
                cnt++;
                if (first < 0) first = m;
            end
        end
        chk("R8 falling edge latency", first, 3);
        chk("R10 falling edge single pulse", cnt, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
        $finish;
    end

endmodule